// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Sticky Status Flags

This block is a 32-bit datapath unit: a combinational arithmetic-logic core and a small registered status word. Each cycle it takes two operands, a five-bit shift count and a four-bit operation code, and it returns the result in the same cycle. The operations are signed and unsigned add and subtract, three bitwise logic operations, left and right logical shifts, an arithmetic right shift, and a merge that places a 16-bit immediate into the low half of a word.

The status word has four flags: negative, overflow, zero and random. The negative, overflow and zero flags are sticky. They change only on a clock edge where `flag_we` is high and the operation code is a defined one, and each class of operation touches only the flags that suit it. The random flag is bit 0 of a 16-bit Galois LFSR. The LFSR steps on every clock edge, so the random flag changes whether or not any operation writes the flags. Branch logic in the surrounding pipeline reads all four flags.

The block has no state machine. The status register and the LFSR are its only state, and both reload on synchronous reset.

Top module: `alu_status_unit`

## Requirements
- R1: Codes 0 (signed add), 1 (unsigned add), 2 (signed subtract) and 3 (unsigned subtract) return `opnd_a + opnd_b` or `opnd_a - opnd_b`, wrapped modulo 2^32.
- R2: When flags are written by code 0 or 1, the overflow flag takes the carry out of bit 31 of the sum.
- R3: When flags are written by code 2, the overflow flag is set on two's-complement overflow. When flags are written by code 3, the overflow flag is set on borrow, that is when `opnd_a` < `opnd_b` unsigned.
- R4: Only codes 0 and 2 write the negative flag, and they load it with bit 31 of the result. Every other code leaves the negative flag unchanged.
- R5: Every defined code (0 to 12) with `flag_we` high loads the zero flag with 1 if the result is all zeroes, else with 0.
- R6: Codes 4 (AND), 5 (OR) and 6 (XOR) return the bitwise result. These codes and code 12 leave the negative and overflow flags unchanged.
- R7: Code 7 shifts left by `shamt` and code 8 shifts left by `opnd_b[4:0]`. Code 9 shifts right logically by `shamt` and code 10 shifts right logically by `opnd_b[4:0]`. Code 11 shifts right arithmetically by `shamt`. The logical shifts fill with zeroes, and code 11 fills with copies of bit 31.
- R8: Left shifts (codes 7 and 8) set the overflow flag when any 1 bit is shifted out. Right shifts (codes 9 to 11) and any shift count of zero clear the overflow flag.
- R9: Code 12 returns `{opnd_a[31:16], opnd_b[15:0]}`.
- R10: Codes 13 to 15 return 0 and leave the negative, overflow and zero flags unchanged. While `flag_we` is low, these three flags hold their values for every code.
- R11: `flag_rand` is bit 0 of a 16-bit Galois LFSR. On each step the LFSR shifts right, and if the bit shifted out was 1 it XORs in the mask 0xB400. Synchronous reset loads the seed 0xACE1. The LFSR steps on every clock edge that is not in reset.
- R12: Synchronous reset clears the negative, overflow and zero flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_sel | input | 4 | Operation code (0 to 15) |
| opnd_a | input | 32 | First operand; shifted value; upper half kept by merge |
| opnd_b | input | 32 | Second operand; variable shift count in bits 4:0; immediate in bits 15:0 |
| shamt | input | 5 | Shift count for the immediate-count shifts |
| flag_we | input | 1 | Write enable for the negative, overflow and zero flags |
| result | output | 32 | Combinational result |
| flag_neg | output | 1 | Negative flag |
| flag_ovf | output | 1 | Overflow / carry / borrow flag |
| flag_zero | output | 1 | Zero flag |
| flag_rand | output | 1 | Random flag |

## Verification
`result` depends only on the inputs of the current cycle, so the bench checks it one time step after it drives the inputs on the falling edge. The flags are due one rising edge after the cycle that wrote them. The bench updates its own flag and LFSR model at that rising edge and compares all four flags on the next falling edge. The random flag steps on every edge, so the bench model steps the LFSR once per cycle for every operation, including cycles where `flag_we` is low.

// File: rtl/alu_status_pkg.sv
package alu_status_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDU = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBU = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_SLL  = 4'd7,
        OP_SLLV = 4'd8,
        OP_SRL  = 4'd9,
        OP_SRLV = 4'd10,
        OP_SRA  = 4'd11,
        OP_LLI  = 4'd12,
        OP_R13  = 4'd13,
        OP_R14  = 4'd14,
        OP_R15  = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic neg;
        logic ovf;
        logic zero;
    } sticky_flags_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import alu_status_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   res,
    output logic           ovf
);
    logic [W:0] sum_ext;
    logic [W:0] dif_ext;

    always_comb begin
        sum_ext = {1'b0, a} + {1'b0, b};
        dif_ext = {1'b0, a} - {1'b0, b};
        res     = '0;
        ovf     = 1'b0;
        unique case (op)
            OP_ADD, OP_ADDU: begin
                res = sum_ext[W-1:0];
                ovf = sum_ext[W];
            end
            OP_SUB: begin
                res = dif_ext[W-1:0];
                ovf = (a[W-1] != b[W-1]) && (dif_ext[W-1] != a[W-1]);
            end
            OP_SUBU: begin
                res = dif_ext[W-1:0];
                ovf = dif_ext[W];
            end
            default: begin
                res = '0;
                ovf = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
    import alu_status_pkg::*;
#(
    parameter int W   = 32,
    parameter int SHW = $clog2(W)
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [SHW-1:0] imm_amt,
    input  logic [SHW-1:0] reg_amt,
    output logic [W-1:0]   res,
    output logic           ovf
);
    logic [SHW-1:0] amt;
    logic [2*W-1:0] wide_l;

    always_comb begin
        amt    = (op == OP_SLLV || op == OP_SRLV) ? reg_amt : imm_amt;
        wide_l = {{W{1'b0}}, a} << amt;
        res    = '0;
        ovf    = 1'b0;
        unique case (op)
            OP_SLL, OP_SLLV: begin
                res = wide_l[W-1:0];
                ovf = |wide_l[2*W-1:W];
            end
            OP_SRL, OP_SRLV: res = a >> amt;
            OP_SRA:          res = $unsigned($signed(a) >>> amt);
            default:         res = '0;
        endcase
    end
endmodule

// File: rtl/alu_lfsr.sv
module alu_lfsr #(
    parameter int          LW   = 16,
    parameter logic [LW-1:0] TAPS = 16'hB400,
    parameter logic [LW-1:0] SEED = 16'hACE1
) (
    input  logic          clk,
    input  logic          rst,
    output logic [LW-1:0] state
);
    logic [LW-1:0] state_nx;

    always_comb begin
        state_nx = state >> 1;
        if (state[0]) begin
            state_nx = state_nx ^ TAPS;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEED;
        end else begin
            state <= state_nx;
        end
    end
endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit
    import alu_status_pkg::*;
#(
    parameter int          W      = 32,
    parameter int          SHW    = $clog2(W),
    parameter int          LW     = 16,
    parameter logic [LW-1:0] TAPS = 16'hB400,
    parameter logic [LW-1:0] SEED = 16'hACE1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [3:0]     op_sel,
    input  logic [W-1:0]   opnd_a,
    input  logic [W-1:0]   opnd_b,
    input  logic [SHW-1:0] shamt,
    input  logic           flag_we,
    output logic [W-1:0]   result,
    output logic           flag_neg,
    output logic           flag_ovf,
    output logic           flag_zero,
    output logic           flag_rand
);
    localparam int HALF = W / 2;

    alu_op_e       op;
    logic [W-1:0]  as_res;
    logic [W-1:0]  sh_res;
    logic          as_ovf;
    logic          sh_ovf;
    logic [LW-1:0] lfsr_q;
    sticky_flags_t flags_q;
    sticky_flags_t flags_nx;

    assign op = alu_op_e'(op_sel);

    alu_addsub #(.W(W)) u_addsub (
        .op  (op),
        .a   (opnd_a),
        .b   (opnd_b),
        .res (as_res),
        .ovf (as_ovf)
    );

    alu_shifter #(.W(W), .SHW(SHW)) u_shift (
        .op      (op),
        .a       (opnd_a),
        .imm_amt (shamt),
        .reg_amt (opnd_b[SHW-1:0]),
        .res     (sh_res),
        .ovf     (sh_ovf)
    );

    alu_lfsr #(.LW(LW), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .state (lfsr_q)
    );

    // result mux
    always_comb begin
        unique case (op)
            OP_ADD, OP_ADDU, OP_SUB, OP_SUBU:         result = as_res;
            OP_AND:                                   result = opnd_a & opnd_b;
            OP_OR:                                    result = opnd_a | opnd_b;
            OP_XOR:                                   result = opnd_a ^ opnd_b;
            OP_SLL, OP_SLLV, OP_SRL, OP_SRLV, OP_SRA: result = sh_res;
            OP_LLI:  result = {opnd_a[W-1:HALF], opnd_b[HALF-1:0]};
            default: result = '0;
        endcase
    end

    // next value of the sticky flags, per operation class
    always_comb begin
        flags_nx      = flags_q;
        flags_nx.zero = (result == '0);
        unique case (op)
            OP_ADD, OP_SUB: begin
                flags_nx.neg = result[W-1];
                flags_nx.ovf = as_ovf;
            end
            OP_ADDU, OP_SUBU: flags_nx.ovf = as_ovf;
            OP_SLL, OP_SLLV, OP_SRL, OP_SRLV, OP_SRA: flags_nx.ovf = sh_ovf;
            OP_AND, OP_OR, OP_XOR, OP_LLI: ;
            default: flags_nx = flags_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else if (flag_we) begin
            flags_q <= flags_nx;
        end
    end

    assign flag_neg  = flags_q.neg;
    assign flag_ovf  = flags_q.ovf;
    assign flag_zero = flags_q.zero;
    assign flag_rand = lfsr_q[0];
endmodule

// File: rtl/alu_status_chk.sv
module alu_status_chk #(
    parameter int W  = 32,
    parameter int LW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic [3:0]    op_sel,
    input logic [W-1:0]  opnd_a,
    input logic          flag_we,
    input logic [W-1:0]  result,
    input logic          flag_neg,
    input logic          flag_ovf,
    input logic          flag_zero,
    input logic [LW-1:0] lfsr_q
);
    localparam int HALF = W / 2;

    // R10
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !flag_we |=> ($stable(flag_neg) && $stable(flag_ovf) && $stable(flag_zero)));

    // R10
    undefined_op_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_we && op_sel > 4'd12) |=> ($stable(flag_neg) && $stable(flag_ovf) && $stable(flag_zero)));

    // R6
    logic_keeps_no_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_we && (op_sel inside {4'd4, 4'd5, 4'd6, 4'd12})) |=> ($stable(flag_neg) && $stable(flag_ovf)));

    // R4
    neg_signed_only_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_we && !(op_sel inside {4'd0, 4'd2})) |=> $stable(flag_neg));

    // R5
    zero_tracks_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_we && op_sel <= 4'd12) |=> (flag_zero == ($past(result) == '0)));

    // R11
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        lfsr_q != '0);

    // R9
    merge_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 4'd12) |-> (result[W-1:HALF] == opnd_a[W-1:HALF]));
endmodule

bind alu_status_unit alu_status_chk #(.W(W), .LW(LW)) u_status_chk (
    .clk       (clk),
    .rst       (rst),
    .op_sel    (op_sel),
    .opnd_a    (opnd_a),
    .flag_we   (flag_we),
    .result    (result),
    .flag_neg  (flag_neg),
    .flag_ovf  (flag_ovf),
    .flag_zero (flag_zero),
    .lfsr_q    (lfsr_q)
);

// File: tb/test_alu_status_unit.sv
module test_alu_status_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  op_sel;
    logic [31:0] opnd_a;
    logic [31:0] opnd_b;
    logic [4:0]  shamt;
    logic        flag_we;
    logic [31:0] result;
    logic        flag_neg;
    logic        flag_ovf;
    logic        flag_zero;
    logic        flag_rand;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    logic        m_neg;
    logic        m_ovf;
    logic        m_zero;
    logic [15:0] m_lfsr;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_status_unit i_alu_status_unit (
        .clk       (clk),
        .rst       (rst),
        .op_sel    (op_sel),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .shamt     (shamt),
        .flag_we   (flag_we),
        .result    (result),
        .flag_neg  (flag_neg),
        .flag_ovf  (flag_ovf),
        .flag_zero (flag_zero),
        .flag_rand (flag_rand)
    );

    function automatic logic [15:0] lfsr_step(logic [15:0] s);
        logic [15:0] n;
        n = s >> 1;
        if (s[0]) n = n ^ 16'hB400;
        return n;
    endfunction

    function automatic logic [31:0] ref_res(int op, logic [31:0] a, logic [31:0] b, logic [4:0] sh);
        case (op)
            0, 1:    return a + b;
            2, 3:    return a - b;
            4:       return a & b;
            5:       return a | b;
            6:       return a ^ b;
            7:       return a << sh;
            8:       return a << b[4:0];
            9:       return a >> sh;
            10:      return a >> b[4:0];
            11:      return $unsigned($signed(a) >>> sh);
            12:      return {a[31:16], b[15:0]};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic left_lost(logic [31:0] a, logic [4:0] n);
        logic [63:0] w;
        w = {32'h0, a} << n;
        return |w[63:32];
    endfunction

    function automatic string res_tag(int op);
        if (op <= 3) return "R1";
        if (op <= 6) return "R6";
        if (op <= 11) return "R7";
        if (op == 12) return "R9";
        return "R10";
    endfunction

    function automatic string ovf_tag(int op);
        if (op <= 1) return "R2";
        if (op <= 3) return "R3";
        if (op >= 7 && op <= 11) return "R8";
        return "R10";
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(int op, logic [31:0] a, logic [31:0] b, logic [4:0] sh, logic we);
        logic [31:0] r;
        logic [32:0] s33;
        op_sel  = op[3:0];
        opnd_a  = a;
        opnd_b  = b;
        shamt   = sh;
        flag_we = we;
        r = ref_res(op, a, b, sh);
        #1;
        chk(res_tag(op), "result", result, r);
        @(posedge clk);
        if (we && op <= 12) begin
            m_zero = (r == 32'h0);
            case (op)
                0: begin s33 = {1'b0, a} + {1'b0, b}; m_ovf = s33[32]; m_neg = r[31]; end
                1: begin s33 = {1'b0, a} + {1'b0, b}; m_ovf = s33[32]; end
                2: begin m_ovf = (a[31] != b[31]) && (r[31] != a[31]); m_neg = r[31]; end
                3: m_ovf = (a < b);
                7: m_ovf = left_lost(a, sh);
                8: m_ovf = left_lost(a, b[4:0]);
                9, 10, 11: m_ovf = 1'b0;
                default: ;
            endcase
        end
        m_lfsr = lfsr_step(m_lfsr);
        @(negedge clk);
        chk("R4", "flag_neg", {31'h0, flag_neg}, {31'h0, m_neg});
        chk(ovf_tag(op), "flag_ovf", {31'h0, flag_ovf}, {31'h0, m_ovf});
        chk("R5", "flag_zero", {31'h0, flag_zero}, {31'h0, m_zero});
        chk("R11", "flag_rand", {31'h0, flag_rand}, {31'h0, m_lfsr[0]});
    endtask

    function automatic logic [31:0] pick_val();
        case ($urandom_range(0, 7))
            0:       return 32'h0;
            1:       return 32'hFFFF_FFFF;
            2:       return 32'h8000_0000;
            3:       return 32'h7FFF_FFFF;
            4:       return 32'h0000_0001;
            default: return $urandom();
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; op_sel = 4'd0; opnd_a = '0; opnd_b = '0; shamt = '0; flag_we = 1'b0;
        m_neg = 1'b0; m_ovf = 1'b0; m_zero = 1'b0; m_lfsr = 16'hACE1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R12 reset state, R11 seed visible
        chk("R12", "reset flags", {29'h0, flag_neg, flag_ovf, flag_zero}, 32'h0);
        chk("R11", "seed bit", {31'h0, flag_rand}, 32'h1);

        // R2 carry out and zero result
        step(0, 32'hFFFF_FFFF, 32'h1, 5'd0, 1'b1);
        // R3 signed overflow on subtract, negative result
        step(2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0, 1'b1);
        // R6 logic keeps N and O
        step(5, 32'h0, 32'h0, 5'd0, 1'b1);
        // R3 borrow on unsigned subtract; R4 N unchanged
        step(3, 32'h1, 32'h2, 5'd0, 1'b1);
        // R8 zero-count shift clears O
        step(7, 32'hF000_0000, 32'h0, 5'd0, 1'b1);
        // R8 left shift losing bits; count from opnd_b[4:0]
        step(8, 32'hC000_0001, 32'h0000_0021, 5'd0, 1'b1);
        // R7 arithmetic right shift of a negative value
        step(11, 32'h8000_00F0, 32'h0, 5'd4, 1'b1);
        // R7 variable logical right shift
        step(10, 32'h8000_0000, 32'hFFFF_FFFF, 5'd0, 1'b1);
        // R9 merge
        step(12, 32'hDEAD_BEEF, 32'h1234_5678, 5'd0, 1'b1);
        // R10 undefined codes and write enable low
        step(14, 32'h0, 32'h0, 5'd0, 1'b1);
        step(2, 32'h0, 32'h1, 5'd0, 1'b0);
        step(15, 32'h5, 32'h5, 5'd3, 1'b1);

        for (int i = 0; i < 3000; i++) begin
            step($urandom_range(0, 15), pick_val(), pick_val(), 5'($urandom()), ($urandom_range(0, 3) != 0));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule